// File: doc/BRIEF.md
# Single-Dword Register Completer Bridge

This block lets a host reach 32-bit registers through a PCIe endpoint. It takes decoded request headers from the receive transaction stream and classifies each one. A memory read or memory write of exactly one dword becomes a single access on a simple memory-mapped master port. A read returns its data to the host as a completion. A read of any other length, and any other request that expects an answer, is answered with a Completer Abort completion. An oversized write, or any other posted request, is dropped with no visible effect.

The bridge is not pipelined. Only one request is in flight at a time, and the receive side stays not-ready until that request is fully finished.

A separate path forwards one interrupt line to the transmit side. A static mode input selects how it is sent: either as legacy INTx assert and deassert messages, or as one MSI write per rising edge.

Top module: `sdw_completer_bridge`

## Requirements
- R1: A request with command code 2'b00 (memory read) and length 1 causes exactly one master read at the request address. It then produces one completion with status 3'b000, data present, and the data word returned on the master port.
- R2: A request with command code 2'b01 (memory write) and length 1 causes exactly one master write carrying the request address, the data, and the first-dword byte enables as strobes. No completion is produced.
- R3: A memory read whose length is not 1 produces one completion with status 3'b100 and no data. No master access is made.
- R4: A memory write whose length is not 1 produces no master access and no completion, and the bridge is ready again on the next cycle.
- R5: Command code 2'b10 (any other non-posted request) is answered with a status 3'b100 completion without data. Command code 2'b11 (any other posted request) is dropped silently.
- R6: rx_ready is high only while no request is in progress. It stays low from acceptance until the master access and any completion handshake have finished.
- R7: Every completion echoes the requester ID and tag of its request and reports a byte count of 4. Its lower address is {addr[6:2], b}, where b is the index of the lowest set first-dword byte enable, or 0 when none is set.
- R8: A master read or write command, with its address, data and strobes, is held unchanged while m_wait is high.
- R9: With irq_use_msi low, a rising irq_in emits one message of kind 2'b01 (assert) and a falling irq_in emits one message of kind 2'b10 (deassert).
- R10: With irq_use_msi high, each rising irq_in emits one message of kind 2'b11 (MSI request). A falling edge emits nothing.
- R11: After a synchronous active-low reset, the bridge is ready and has no master command, no completion and no interrupt message pending.
- R12: A completion and an interrupt message are each held stable until their own ready is seen. Either one may be pending in the same cycle as the other without disturbing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Request header valid |
| rx_ready | output | 1 | Bridge can accept a request |
| rx_cmd | input | 2 | Request class: 00 read, 01 write, 10 other non-posted, 11 other posted |
| rx_len | input | 10 | Request length in dwords |
| rx_addr | input | 32 | Request byte address |
| rx_be | input | 4 | First-dword byte enables |
| rx_data | input | 32 | Write payload |
| rx_req_id | input | 16 | Requester ID |
| rx_tag | input | 8 | Request tag |
| m_read | output | 1 | Master read command |
| m_write | output | 1 | Master write command |
| m_addr | output | 32 | Master address |
| m_wdata | output | 32 | Master write data |
| m_be | output | 4 | Master byte strobes |
| m_wait | input | 1 | Slave stalls the current command |
| m_rdata | input | 32 | Read data |
| m_rvalid | input | 1 | Read data valid |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Transmit side accepts the completion |
| cpl_status | output | 3 | 000 success, 100 completer abort |
| cpl_has_data | output | 1 | Completion carries one data dword |
| cpl_req_id | output | 16 | Echoed requester ID |
| cpl_tag | output | 8 | Echoed tag |
| cpl_byte_cnt | output | 12 | Byte count |
| cpl_lower_addr | output | 7 | Lower address field |
| cpl_data | output | 32 | Completion data |
| irq_in | input | 1 | Interrupt source level |
| irq_use_msi | input | 1 | Static mode: 1 MSI, 0 INTx |
| irq_msg_valid | output | 1 | Interrupt message valid |
| irq_msg_ready | input | 1 | Transmit side accepts the message |
| irq_msg_kind | output | 2 | 01 INTx assert, 10 INTx deassert, 11 MSI |

## Verification
A completion and an interrupt message can be pending in the same cycle, each waiting on its own ready. The bench provokes this by running two concurrent threads. One issues constrained-random requests against a slave model that has random stalls and read latency, and it drops cpl_ready at random. The other toggles irq_in and holds irq_msg_ready low for random stretches. Each thread judges only its own channel, against values from bench functions, so any interference shows up as a wrong field, a lost message, or a missing handshake. This is repeated in both interrupt modes.

// File: rtl/sdw_pkg.sv
// Shared types and codes for the single-dword completer bridge.
// Assumes requests arrive already split into header fields.
package sdw_pkg;
    typedef enum logic [1:0] {
        RQ_MRD   = 2'b00,
        RQ_MWR   = 2'b01,
        RQ_NP_OT = 2'b10,
        RQ_P_OT  = 2'b11
    } rq_cmd_e;

    typedef enum logic [1:0] {
        ACT_DROP,
        ACT_READ,
        ACT_WRITE,
        ACT_ABORT
    } act_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RWAIT,
        ST_WR,
        ST_CPL
    } st_e;

    localparam logic [2:0] CPL_OK = 3'b000;
    localparam logic [2:0] CPL_CA = 3'b100;

    localparam logic [1:0] IRQ_INTX_ON  = 2'b01;
    localparam logic [1:0] IRQ_INTX_OFF = 2'b10;
    localparam logic [1:0] IRQ_MSI      = 2'b11;
endpackage

// File: rtl/sdw_decode.sv
// Request classifier and lower-address builder.
// Purely combinational. Assumes the fields are stable while rx_valid is high.
module sdw_decode #(
    parameter int LEN_W = 10,
    parameter int BE_W  = 4,
    parameter int LA_W  = 7
) (
    input  logic [1:0]      cmd,
    input  logic [LEN_W-1:0] len,
    input  logic [LA_W-1:2] addr_lo,
    input  logic [BE_W-1:0] be,
    output sdw_pkg::act_e   act,
    output logic [LA_W-1:0] low_addr
);
    import sdw_pkg::*;

    localparam int IDX_W = $clog2(BE_W);

    logic       one_dw;
    logic [1:0] be_idx;

    assign one_dw = (len == LEN_W'(1));

    // Map command class and length to an action.
    always_comb begin
        unique case (rq_cmd_e'(cmd))
            RQ_MRD:   act = one_dw ? ACT_READ  : ACT_ABORT;
            RQ_MWR:   act = one_dw ? ACT_WRITE : ACT_DROP;
            RQ_NP_OT: act = ACT_ABORT;
            default:  act = ACT_DROP;
        endcase
    end

    // Find the lowest enabled byte lane.
    always_comb begin
        be_idx = '0;
        for (int i = BE_W - 1; i >= 0; i--) begin
            if (be[i]) be_idx = 2'(i);
        end
    end

    assign low_addr = {addr_lo, be_idx[IDX_W-1:0]};
endmodule

// File: rtl/sdw_ctrl.sv
// Request sequencer. It accepts one request, runs one master access or
// builds an abort, and returns a completion when one is due.
// Assumes the master slave gives read data after the read command is taken.
module sdw_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int RID_W  = 16,
    parameter int TAG_W  = 8,
    parameter int LA_W   = 7,
    parameter int BC_W   = 12,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  sdw_pkg::act_e     act,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [BE_W-1:0]   rx_be,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [RID_W-1:0]  rx_req_id,
    input  logic [TAG_W-1:0]  rx_tag,
    input  logic [LA_W-1:0]   low_addr,
    output logic              m_read,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic [BE_W-1:0]   m_be,
    input  logic              m_wait,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_rvalid,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [2:0]        cpl_status,
    output logic              cpl_has_data,
    output logic [RID_W-1:0]  cpl_req_id,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [BC_W-1:0]   cpl_byte_cnt,
    output logic [LA_W-1:0]   cpl_lower_addr,
    output logic [DATA_W-1:0] cpl_data
);
    import sdw_pkg::*;

    localparam logic [BC_W-1:0] DW_BYTES = BC_W'(BE_W);

    st_e               state_q;
    logic [2:0]        status_q;
    logic              hasd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [BE_W-1:0]   be_q;
    logic [RID_W-1:0]  rid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LA_W-1:0]   la_q;
    logic              accept;

    assign accept = rx_valid && (state_q == ST_IDLE);

    // Step the request sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            status_q <= CPL_OK;
            hasd_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (rx_valid) begin
                    unique case (act)
                        ACT_READ:  state_q <= ST_RD;
                        ACT_WRITE: state_q <= ST_WR;
                        ACT_ABORT: begin
                            state_q  <= ST_CPL;
                            status_q <= CPL_CA;
                            hasd_q   <= 1'b0;
                        end
                        default:   state_q <= ST_IDLE;
                    endcase
                end
                ST_RD:    if (!m_wait) state_q <= ST_RWAIT;
                ST_RWAIT: if (m_rvalid) begin
                    state_q  <= ST_CPL;
                    status_q <= CPL_OK;
                    hasd_q   <= 1'b1;
                end
                ST_WR:    if (!m_wait) state_q <= ST_IDLE;
                ST_CPL:   if (cpl_ready) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the request fields when a request is taken.
    always_ff @(posedge clk) begin
        if (accept) begin
            addr_q  <= rx_addr;
            wdata_q <= rx_data;
            be_q    <= rx_be;
            rid_q   <= rx_req_id;
            tag_q   <= rx_tag;
            la_q    <= low_addr;
        end
    end

    // Capture returned read data.
    always_ff @(posedge clk) begin
        if (state_q == ST_RWAIT && m_rvalid) rdata_q <= m_rdata;
    end

    assign rx_ready       = (state_q == ST_IDLE);
    assign m_read         = (state_q == ST_RD);
    assign m_write        = (state_q == ST_WR);
    assign m_addr         = addr_q;
    assign m_wdata        = wdata_q;
    assign m_be           = be_q;
    assign cpl_valid      = (state_q == ST_CPL);
    assign cpl_status     = status_q;
    assign cpl_has_data   = hasd_q;
    assign cpl_req_id     = rid_q;
    assign cpl_tag        = tag_q;
    assign cpl_byte_cnt   = DW_BYTES;
    assign cpl_lower_addr = la_q;
    assign cpl_data       = rdata_q;

    // R1: a one-dword read starts a master read next cycle.
    a_r1_read_issued: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && act == ACT_READ) |=> m_read);
    // R2: a one-dword write starts a master write next cycle.
    a_r2_write_issued: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && act == ACT_WRITE) |=> m_write && !cpl_valid);
    // R3 and R5: an abort goes straight to a data-less abort completion.
    a_r3_abort_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && act == ACT_ABORT) |=>
        cpl_valid && cpl_status == CPL_CA && !cpl_has_data && !m_read);
    // R4: a dropped request leaves the bridge idle.
    a_r4_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && act == ACT_DROP) |=>
        rx_ready && !m_write && !m_read && !cpl_valid);
    // R8: stalled read command is held.
    a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_read && m_wait) |=> m_read && $stable(m_addr));
    // R8: stalled write command is held.
    a_r8_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && m_wait) |=> m_write && $stable(m_addr) && $stable(m_wdata) && $stable(m_be));
    // R12: an unaccepted completion is held.
    a_r12_cpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=>
        cpl_valid && $stable(cpl_tag) && $stable(cpl_status) && $stable(cpl_data));
    // R6: at most one of the busy indications at a time.
    a_r6_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ready, m_read, m_write, cpl_valid}));
endmodule

// File: rtl/sdw_irq.sv
// Interrupt forwarder for one source. It emits INTx assert and deassert
// messages, or one MSI request per rising edge, as set by a static mode input.
// Assumes irq_in is already synchronous to clk.
module sdw_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_in,
    input  logic       irq_use_msi,
    output logic       irq_msg_valid,
    input  logic       irq_msg_ready,
    output logic [1:0] irq_msg_kind
);
    import sdw_pkg::*;

    logic irq_s, sent_lvl, msi_pend, valid_q;
    logic [1:0] kind_q;
    logic take, free, rise, pend_n;

    assign take   = valid_q && irq_msg_ready;
    assign free   = !valid_q || take;
    assign rise   = irq_in && !irq_s;
    assign pend_n = msi_pend || rise;

    // Track edges and issue one message at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_s    <= 1'b0;
            sent_lvl <= 1'b0;
            msi_pend <= 1'b0;
            valid_q  <= 1'b0;
            kind_q   <= IRQ_INTX_OFF;
        end else begin
            irq_s <= irq_in;
            if (irq_use_msi) begin
                if (free && pend_n) begin
                    valid_q  <= 1'b1;
                    kind_q   <= IRQ_MSI;
                    msi_pend <= 1'b0;
                end else begin
                    msi_pend <= pend_n;
                    if (take) valid_q <= 1'b0;
                end
            end else begin
                msi_pend <= 1'b0;
                if (free && (irq_in != sent_lvl)) begin
                    valid_q  <= 1'b1;
                    kind_q   <= irq_in ? IRQ_INTX_ON : IRQ_INTX_OFF;
                    sent_lvl <= irq_in;
                end else if (take) begin
                    valid_q <= 1'b0;
                end
            end
        end
    end

    assign irq_msg_valid = valid_q;
    assign irq_msg_kind  = kind_q;

    // R12: a pending message is held until accepted.
    a_r12_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_msg_valid && !irq_msg_ready) |=> irq_msg_valid && $stable(irq_msg_kind));
    // R10: MSI mode only sends MSI requests.
    a_r10_msi_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_use_msi && $rose(irq_msg_valid)) |-> irq_msg_kind == IRQ_MSI);
    // R9: INTx mode never sends an MSI request.
    a_r9_intx_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_use_msi && $rose(irq_msg_valid)) |-> irq_msg_kind != IRQ_MSI);
endmodule

// File: rtl/sdw_completer_bridge.sv
// Top of the single-dword completer bridge. It ties the classifier, the
// request sequencer and the interrupt forwarder together.
// Assumes a well-formed request header is presented with rx_valid.
module sdw_completer_bridge #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 10,
    parameter int RID_W  = 16,
    parameter int TAG_W  = 8,
    parameter int BC_W   = 12,
    localparam int BE_W  = DATA_W / 8,
    localparam int LA_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [1:0]        rx_cmd,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [BE_W-1:0]   rx_be,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [RID_W-1:0]  rx_req_id,
    input  logic [TAG_W-1:0]  rx_tag,
    output logic              m_read,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic [BE_W-1:0]   m_be,
    input  logic              m_wait,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_rvalid,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [2:0]        cpl_status,
    output logic              cpl_has_data,
    output logic [RID_W-1:0]  cpl_req_id,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [BC_W-1:0]   cpl_byte_cnt,
    output logic [LA_W-1:0]   cpl_lower_addr,
    output logic [DATA_W-1:0] cpl_data,
    input  logic              irq_in,
    input  logic              irq_use_msi,
    output logic              irq_msg_valid,
    input  logic              irq_msg_ready,
    output logic [1:0]        irq_msg_kind
);
    sdw_pkg::act_e   act;
    logic [LA_W-1:0] low_addr;

    sdw_decode #(.LEN_W(LEN_W), .BE_W(BE_W), .LA_W(LA_W)) u_decode (
        .cmd      (rx_cmd),
        .len      (rx_len),
        .addr_lo  (rx_addr[LA_W-1:2]),
        .be       (rx_be),
        .act      (act),
        .low_addr (low_addr)
    );

    sdw_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RID_W(RID_W),
        .TAG_W(TAG_W), .LA_W(LA_W), .BC_W(BC_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_valid       (rx_valid),
        .rx_ready       (rx_ready),
        .act            (act),
        .rx_addr        (rx_addr),
        .rx_be          (rx_be),
        .rx_data        (rx_data),
        .rx_req_id      (rx_req_id),
        .rx_tag         (rx_tag),
        .low_addr       (low_addr),
        .m_read         (m_read),
        .m_write        (m_write),
        .m_addr         (m_addr),
        .m_wdata        (m_wdata),
        .m_be           (m_be),
        .m_wait         (m_wait),
        .m_rdata        (m_rdata),
        .m_rvalid       (m_rvalid),
        .cpl_valid      (cpl_valid),
        .cpl_ready      (cpl_ready),
        .cpl_status     (cpl_status),
        .cpl_has_data   (cpl_has_data),
        .cpl_req_id     (cpl_req_id),
        .cpl_tag        (cpl_tag),
        .cpl_byte_cnt   (cpl_byte_cnt),
        .cpl_lower_addr (cpl_lower_addr),
        .cpl_data       (cpl_data)
    );

    sdw_irq u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_in        (irq_in),
        .irq_use_msi   (irq_use_msi),
        .irq_msg_valid (irq_msg_valid),
        .irq_msg_ready (irq_msg_ready),
        .irq_msg_kind  (irq_msg_kind)
    );
endmodule

// File: tb/sdw_completer_bridge_tb.sv
`timescale 1ns/1ps
module sdw_completer_bridge_tb;
    logic clk = 0, rst_n = 0;
    logic rx_valid = 0, m_wait = 0, m_rvalid = 0, cpl_ready = 0;
    logic irq_in = 0, irq_use_msi = 0, irq_msg_ready = 0;
    logic [1:0] rx_cmd = 0;
    logic [9:0] rx_len = 0;
    logic [31:0] rx_addr = 0, rx_data = 0, m_rdata = 0;
    logic [3:0] rx_be = 0;
    logic [15:0] rx_req_id = 0;
    logic [7:0] rx_tag = 0;
    logic rx_ready, m_read, m_write, cpl_valid, cpl_has_data, irq_msg_valid;
    logic [31:0] m_addr, m_wdata, cpl_data;
    logic [3:0] m_be;
    logic [2:0] cpl_status;
    logic [15:0] cpl_req_id;
    logic [7:0] cpl_tag;
    logic [11:0] cpl_byte_cnt;
    logic [6:0] cpl_lower_addr;
    logic [1:0] irq_msg_kind;

    int checks = 0, errors = 0, overlap = 0;
    logic [31:0] mem [16];

    sdw_completer_bridge u_dut (.*);

    always #4 clk = ~clk;

    always @(negedge clk) if (cpl_valid && irq_msg_valid) overlap++;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // 0 drop, 1 read, 2 write, 3 abort
    function automatic int exp_act(input logic [1:0] cmd, input int len);
        case (cmd)
            2'b00: return (len == 1) ? 1 : 3;
            2'b01: return (len == 1) ? 2 : 0;
            2'b10: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic [6:0] exp_la(input logic [31:0] a, input logic [3:0] be);
        logic [1:0] b;
        casez (be)
            4'b???1: b = 2'd0;
            4'b??10: b = 2'd1;
            4'b?100: b = 2'd2;
            4'b1000: b = 2'd3;
            default: b = 2'd0;
        endcase
        return {a[6:2], b};
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    task automatic run_req(input logic [1:0] cmd, input int len, input logic [31:0] addr,
                           input logic [3:0] be, input logic [31:0] wd);
        int wr_seen = 0, rd_seen = 0, cpl_seen = 0, lat = 0, cyc = 0, a;
        bit rd_acc = 0, wr_chk = 0, cpl_chk = 0;
        logic [31:0] rd_ret = 0;
        logic [15:0] rid = 16'($urandom);
        logic [7:0] tag = 8'($urandom);
        a = exp_act(cmd, len);
        @(negedge clk);
        chk(rx_ready == 1'b1, "R6 ready when idle", rx_ready, 1);
        rx_cmd = cmd; rx_len = 10'(len); rx_addr = addr; rx_be = be;
        rx_data = wd; rx_req_id = rid; rx_tag = tag; rx_valid = 1;
        @(negedge clk);
        rx_valid = 0;
        if (a == 0) chk(rx_ready && !m_write && !m_read && !cpl_valid, "R4/R5 drop leaves idle", rx_ready, 1);
        while (!(rx_ready && !m_read && !m_write && !cpl_valid) && cyc < 200) begin
            m_rvalid = 0;
            if (rx_ready) chk(0, "R6 ready while busy", rx_ready, 0);
            if (m_write) begin
                if (!wr_chk) begin
                    wr_chk = 1;
                    chk(m_addr == addr && m_wdata == wd && m_be == be, "R2 write fields",
                        {m_addr, m_wdata}, {addr, wd});
                end
                m_wait = 1'($urandom % 2);
                if (!m_wait) begin wr_seen++; mem[addr[5:2]] = merge(mem[addr[5:2]], wd, be); end
            end else if (m_read) begin
                if (!rd_acc && rd_seen == 0) chk(m_addr == addr, "R1 read address", m_addr, addr);
                m_wait = 1'($urandom % 2);
                if (!m_wait) begin rd_seen++; rd_acc = 1; lat = $urandom % 3; end
            end else if (rd_acc) begin
                if (lat == 0) begin
                    rd_ret = mem[addr[5:2]]; m_rdata = rd_ret; m_rvalid = 1; rd_acc = 0;
                end else lat--;
            end
            if (cpl_valid) begin
                if (!cpl_chk) begin
                    cpl_chk = 1;
                    chk(cpl_req_id == rid && cpl_tag == tag, "R7 id and tag echo",
                        {cpl_req_id, cpl_tag}, {rid, tag});
                    chk(cpl_byte_cnt == 12'd4, "R7 byte count", cpl_byte_cnt, 4);
                    chk(cpl_lower_addr == exp_la(addr, be), "R7 lower address", cpl_lower_addr, exp_la(addr, be));
                    if (a == 1)
                        chk(cpl_status == 3'b000 && cpl_has_data && cpl_data == rd_ret,
                            "R1 read completion", {cpl_status, cpl_data}, {3'b000, rd_ret});
                    else
                        chk(cpl_status == 3'b100 && !cpl_has_data, "R3/R5 abort completion",
                            {cpl_has_data, cpl_status}, {1'b0, 3'b100});
                end
                cpl_ready = 1'($urandom % 2);
                if (cpl_ready) cpl_seen++;
            end else cpl_ready = 0;
            @(negedge clk);
            cyc++;
        end
        m_wait = 0; m_rvalid = 0; cpl_ready = 0;
        chk(wr_seen == (a == 2 ? 1 : 0), "R2/R4 master write count", wr_seen, a == 2);
        chk(rd_seen == (a == 1 ? 1 : 0), "R1/R3 master read count", rd_seen, a == 1);
        chk(cpl_seen == ((a == 1 || a == 3) ? 1 : 0), "R1/R3/R5 completion count", cpl_seen, a == 1 || a == 3);
    endtask

    task automatic expect_msg(input logic [1:0] kind, input string req);
        int w = 0;
        @(negedge clk);
        while (!irq_msg_valid && w < 10) begin @(negedge clk); w++; end
        chk(irq_msg_valid && irq_msg_kind == kind, req, {irq_msg_valid, irq_msg_kind}, {1'b1, kind});
        repeat ($urandom % 4) begin
            @(negedge clk);
            chk(irq_msg_valid && irq_msg_kind == kind, "R12 message held", irq_msg_kind, kind);
        end
        irq_msg_ready = 1;
        @(negedge clk);
        irq_msg_ready = 0;
        chk(!irq_msg_valid, "R12 message cleared after accept", irq_msg_valid, 0);
    endtask

    task automatic irq_proc(input bit msi);
        for (int i = 0; i < 10; i++) begin
            repeat (3 + $urandom % 15) @(negedge clk);
            irq_in = 1;
            expect_msg(msi ? 2'b11 : 2'b01, msi ? "R10 MSI on rise" : "R9 INTx assert");
            repeat (2 + $urandom % 10) @(negedge clk);
            irq_in = 0;
            if (msi) begin
                repeat (3) begin
                    @(negedge clk);
                    chk(!irq_msg_valid, "R10 no message on fall", irq_msg_valid, 0);
                end
            end else expect_msg(2'b10, "R9 INTx deassert");
        end
    endtask

    task automatic req_proc(input int n);
        run_req(2'b01, 1, 32'h0000_0010, 4'hF, 32'hA5A5_1234);
        run_req(2'b00, 1, 32'h0000_0010, 4'hF, 0);
        run_req(2'b01, 1, 32'h0000_0010, 4'b0110, 32'hFFFF_FFFF);
        run_req(2'b00, 1, 32'h0000_007C, 4'b1000, 0);
        run_req(2'b00, 2, 32'h0000_0020, 4'hF, 0);
        run_req(2'b00, 0, 32'h0000_0024, 4'b0100, 0);
        run_req(2'b01, 4, 32'h0000_0010, 4'hF, 32'h1111_1111);
        run_req(2'b00, 1, 32'h0000_0010, 4'b0000, 0);
        run_req(2'b10, 1, 32'h0000_0044, 4'b0010, 0);
        run_req(2'b11, 1, 32'h0000_0048, 4'hF, 32'h2222_2222);
        for (int i = 0; i < n; i++)
            run_req(2'($urandom), ($urandom % 2) ? 1 : int'($urandom % 6),
                    $urandom & 32'hFFFF_FFFC, 4'($urandom), $urandom);
    endtask

    task automatic do_reset(input bit msi);
        rst_n = 0; irq_use_msi = msi; irq_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rx_ready && !m_read && !m_write && !cpl_valid && !irq_msg_valid,
            "R11 reset state", {rx_ready, m_read, m_write, cpl_valid, irq_msg_valid}, 5'b10000);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + i;
        do_reset(0);
        fork
            req_proc(60);
            irq_proc(0);
        join
        do_reset(1);
        fork
            req_proc(60);
            irq_proc(1);
        join
        $display("completion/interrupt overlap cycles: %0d", overlap);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule